// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block caches recent virtual-to-physical page translations so a memory access can be translated without a page table walk. Each line holds a tag made of a process identifier and a virtual page number, and a payload made of a physical page number and flag bits: valid, read permission, write permission, dirty and recently used. A lookup takes a 32-bit virtual address and a process identifier. In the same cycle it returns hit or miss, the 30-bit physical address and a permission fault. It also raises a request when a write lands on a clean page.

On a miss, the walker outside this block fetches the page table entry and writes it in through the refill port. Refill first reuses a line that already holds the same tag, then the lowest free line, and otherwise picks a victim with a clock sweep over the use bits. A flush port clears either every line or only the lines of one process, so a context switch does not have to discard the translations of other processes.

Top module: `xlat_cache`

## Requirements
- R1: With `lk_valid` high, a valid line whose process identifier and virtual page number (address bits 31:12) both match gives `lk_hit`=1 in the same cycle, and `lk_paddr` = {stored page number, address bits 11:0}. Without a hit, `lk_paddr` is zero. With `lk_valid` low, `lk_hit` is 0.
- R2: A line filled for one process never hits for a different identifier that uses the same virtual page number.
- R3: `lk_fault` is 1 only on a hit: on a read (`lk_write`=0) to a line whose read bit is clear, or on a write to a line whose write bit is clear. A miss gives `lk_fault`=0.
- R4: A write hit to a line that allows writes and whose dirty bit is clear raises `lk_dirty_upd` in that cycle and sets the dirty bit of the line. The next write to the same line does not raise it.
- R5: A refill whose process identifier and page number are already present overwrites that line, so the next lookup returns the new page number and there is never more than one matching line.
- R6: A refill of a new tag takes the lowest-numbered invalid line before any line is evicted.
- R7: When all lines are valid, the victim is found by sweeping from a pointer (zero after reset) to the first line with its use bit clear, clearing the use bits of the lines passed. If no use bit is clear, the victim is the line at the pointer and all use bits are cleared. The pointer then moves one past the victim. A lookup hit sets the line's use bit, and so does a refill.
- R8: `flush_asid_en` invalidates exactly the lines whose identifier equals `flush_asid` and leaves all other lines intact.
- R9: `flush_all` invalidates every line in one cycle. A flush of either kind takes priority over a refill in the same cycle, and that refill is dropped.
- R10: After reset, every line is invalid and lookups miss with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a store (1) or a load (0) |
| lk_asid | input | 8 | Process identifier of the lookup |
| lk_vaddr | input | 32 | Virtual address |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 30 | Physical address |
| lk_fault | output | 1 | Permission violation on a hit |
| lk_dirty_upd | output | 1 | First write to a clean page; the page table dirty bit must be set |
| fill_en | input | 1 | Refill strobe |
| fill_asid | input | 8 | Refill process identifier |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_ppn | input | 18 | Refill physical page number |
| fill_rd | input | 1 | Refill read permission |
| fill_wr | input | 1 | Refill write permission |
| fill_dirty | input | 1 | Refill dirty bit |
| flush_all | input | 1 | Invalidate all lines |
| flush_asid_en | input | 1 | Invalidate the lines of one process |
| flush_asid | input | 8 | Process whose lines are invalidated |

## Verification
The bench uses the same page number under two process identifiers. A design that compared only the page would hit for the wrong process or return the wrong physical page. It writes twice to a clean page, so a design that failed to record the dirty bit would request the page table update a second time. It refills a tag that is already present and expects the new page number. A design that put the refill in a fresh line would keep returning the stale page from the lower-numbered duplicate. It frees one line in a full cache and then drives a chain of evictions with a selected use bit set, so a wrong free-line preference, a pointer that does not advance, or a sweep that neither skips nor clears used lines would evict a line the bench expects to survive.

// File: rtl/xc_pkg.sv
package xc_pkg;
   typedef struct packed {
      logic valid;
      logic rd;
      logic wr;
      logic dirty;
      logic used;
   } xc_flags_t;
endpackage

// File: rtl/xc_prio.sv
module xc_prio #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/xc_match.sv
module xc_match #(
   parameter int DEPTH = 16,
   parameter int TAG_W = 28,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]            valid,
   input  logic [DEPTH-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]            key,
   output logic [DEPTH-1:0]            hits,
   output logic                        hit,
   output logic [IDX_W-1:0]            idx
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hits[g] = valid[g] && (tags[g] == key);
   end

   xc_prio #(.DEPTH(DEPTH)) u_enc (.req(hits), .any(hit), .idx(idx));
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] used,
   input  logic [IDX_W-1:0] ptr,
   output logic [IDX_W-1:0] victim,
   output logic [DEPTH-1:0] clr_mask
);
   always_comb begin
      logic             found;
      logic [IDX_W-1:0] k;
      found    = 1'b0;
      victim   = ptr;
      clr_mask = '0;
      for (int off = 0; off < DEPTH; off++) begin
         k = IDX_W'(int'(ptr) + off);
         if (!found) begin
            if (!used[k]) begin
               found  = 1'b1;
               victim = k;
            end else begin
               clr_mask[k] = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xc_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 30,
   parameter int OFS_W  = 12,
   parameter int ASID_W = 8,
   parameter int DEPTH  = 16,
   localparam int VPN_W = VA_W - OFS_W,
   localparam int PPN_W = PA_W - OFS_W,
   localparam int TAG_W = ASID_W + VPN_W,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic              lk_write,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [VA_W-1:0]   lk_vaddr,
   output logic              lk_hit,
   output logic [PA_W-1:0]   lk_paddr,
   output logic              lk_fault,
   output logic              lk_dirty_upd,
   input  logic              fill_en,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic              fill_rd,
   input  logic              fill_wr,
   input  logic              fill_dirty,
   input  logic              flush_all,
   input  logic              flush_asid_en,
   input  logic [ASID_W-1:0] flush_asid
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 2");
   end
   if (PA_W <= OFS_W || VA_W <= OFS_W) begin : g_bad_width
      $error("address widths must exceed the page offset width");
   end

   logic [DEPTH-1:0][TAG_W-1:0] tag_q;
   logic [DEPTH-1:0][PPN_W-1:0] ppn_q;
   xc_flags_t                   flg_q [DEPTH];
   logic [IDX_W-1:0]            ptr_q;

   logic [DEPTH-1:0] valid_v, used_v, asid_hit;
   for (genvar g = 0; g < DEPTH; g++) begin : g_vec
      assign valid_v[g]  = flg_q[g].valid;
      assign used_v[g]   = flg_q[g].used;
      assign asid_hit[g] = (tag_q[g][TAG_W-1:VPN_W] == flush_asid);
   end

   // lookup path
   logic [DEPTH-1:0] lk_hits;
   logic             lk_any;
   logic [IDX_W-1:0] lk_idx;
   xc_flags_t        lk_f;

   xc_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_lk (
      .valid(valid_v), .tags(tag_q), .key({lk_asid, lk_vaddr[VA_W-1:OFS_W]}),
      .hits(lk_hits), .hit(lk_any), .idx(lk_idx));

   assign lk_f         = flg_q[lk_idx];
   assign lk_hit       = lk_valid && lk_any;
   assign lk_fault     = lk_hit && (lk_write ? !lk_f.wr : !lk_f.rd);
   assign lk_dirty_upd = lk_hit && lk_write && lk_f.wr && !lk_f.dirty;
   assign lk_paddr     = lk_hit ? {ppn_q[lk_idx], lk_vaddr[OFS_W-1:0]} : '0;

   // refill placement
   logic [DEPTH-1:0] fm_hits, clr_mask;
   logic             fm_any, free_any;
   logic [IDX_W-1:0] fm_idx, free_idx, vic_idx, fill_idx;
   logic             fill_go, use_clock;

   xc_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_fm (
      .valid(valid_v), .tags(tag_q), .key({fill_asid, fill_vpn}),
      .hits(fm_hits), .hit(fm_any), .idx(fm_idx));

   xc_prio #(.DEPTH(DEPTH)) u_free (.req(~valid_v), .any(free_any), .idx(free_idx));

   xc_victim #(.DEPTH(DEPTH)) u_vic (
      .used(used_v), .ptr(ptr_q), .victim(vic_idx), .clr_mask(clr_mask));

   assign fill_go   = fill_en && !flush_all && !flush_asid_en;
   assign use_clock = !fm_any && !free_any;
   assign fill_idx  = fm_any ? fm_idx : (free_any ? free_idx : vic_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            flg_q[i] <= '0;
            tag_q[i] <= '0;
            ppn_q[i] <= '0;
         end
         ptr_q <= '0;
      end else begin
         if (fill_go && use_clock) begin
            for (int i = 0; i < DEPTH; i++) begin
               if (clr_mask[i]) flg_q[i].used <= 1'b0;
            end
            ptr_q <= vic_idx + 1'b1;
         end
         if (lk_hit) begin
            flg_q[lk_idx].used <= 1'b1;
            if (lk_dirty_upd) flg_q[lk_idx].dirty <= 1'b1;
         end
         if (fill_go) begin
            tag_q[fill_idx] <= {fill_asid, fill_vpn};
            ppn_q[fill_idx] <= fill_ppn;
            flg_q[fill_idx] <= '{valid: 1'b1, rd: fill_rd, wr: fill_wr,
                                 dirty: fill_dirty, used: 1'b1};
         end
         for (int i = 0; i < DEPTH; i++) begin
            if (flush_all || (flush_asid_en && asid_hit[i])) flg_q[i].valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/xc_chk.sv
module xc_chk #(
   parameter int DEPTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic             lk_write,
   input logic             lk_hit,
   input logic             lk_fault,
   input logic             lk_dirty_upd,
   input logic             flush_all,
   input logic [DEPTH-1:0] hit_vec
);
   a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   a_r1_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_valid);

   a_r3_fault_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> lk_hit);

   a_r4_dirty_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      lk_dirty_upd |-> (lk_hit && lk_write && !lk_fault));

   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !lk_hit);
endmodule

bind xlat_cache xc_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
   .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_dirty_upd(lk_dirty_upd),
   .flush_all(flush_all), .hit_vec(lk_hits));

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0, lk_write = 1'b0;
   logic [7:0]  lk_asid = '0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_hit, lk_fault, lk_dirty_upd;
   logic [29:0] lk_paddr;
   logic        fill_en = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0, fill_dirty = 1'b0;
   logic [7:0]  fill_asid = '0;
   logic [19:0] fill_vpn = '0;
   logic [17:0] fill_ppn = '0;
   logic        flush_all = 1'b0, flush_asid_en = 1'b0;
   logic [7:0]  flush_asid = '0;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   xlat_cache dut_i (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
      .lk_asid(lk_asid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
      .lk_fault(lk_fault), .lk_dirty_upd(lk_dirty_upd), .fill_en(fill_en),
      .fill_asid(fill_asid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_dirty(fill_dirty),
      .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid));

   typedef struct packed {
      logic [7:0]  asid;
      logic [19:0] vpn;
      logic        wr;
      logic        hit;
      logic [17:0] ppn;
      logic        fault;
      logic        du;
   } vec_t;

   localparam logic [11:0] OFS = 12'hABC;

   localparam vec_t VEC [9] = '{
      '{8'd1, 20'h00010, 1'b0, 1'b1, 18'h00AA1, 1'b0, 1'b0},  // R1 plain read hit
      '{8'd2, 20'h00010, 1'b0, 1'b1, 18'h00BB2, 1'b0, 1'b0},  // R2 same page, other process
      '{8'd3, 20'h00010, 1'b0, 1'b0, 18'h00000, 1'b0, 1'b0},  // R2 unknown process misses
      '{8'd2, 20'h00010, 1'b1, 1'b1, 18'h00BB2, 1'b1, 1'b0},  // R3 write to read-only
      '{8'd1, 20'h00020, 1'b0, 1'b1, 18'h3FFFF, 1'b1, 1'b0},  // R3 read to no-read
      '{8'd1, 20'h00020, 1'b1, 1'b1, 18'h3FFFF, 1'b0, 1'b0},  // R4 already dirty
      '{8'd1, 20'h00010, 1'b1, 1'b1, 18'h00AA1, 1'b0, 1'b1},  // R4 first write to clean
      '{8'd1, 20'h00010, 1'b1, 1'b1, 18'h00AA1, 1'b0, 1'b0},  // R4 dirty now recorded
      '{8'd1, 20'h00030, 1'b1, 1'b0, 18'h00000, 1'b0, 1'b0}   // R3 miss never faults
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic fill(input logic [7:0] a, input logic [19:0] v, input logic [17:0] p,
                       input bit r, input bit w, input bit d);
      @(negedge clk);
      fill_en = 1'b1; fill_asid = a; fill_vpn = v; fill_ppn = p;
      fill_rd = r; fill_wr = w; fill_dirty = d;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic look(input string req, input logic [7:0] a, input logic [19:0] v,
                       input bit w, input bit eh, input logic [17:0] ep,
                       input bit ef, input bit ed);
      @(negedge clk);
      lk_valid = 1'b1; lk_write = w; lk_asid = a; lk_vaddr = {v, OFS};
      #2;
      chk(lk_hit == eh, req, "hit", 64'(lk_hit), 64'(eh));
      chk(lk_paddr == (eh ? {ep, OFS} : 30'd0), req, "paddr", 64'(lk_paddr),
          64'(eh ? {ep, OFS} : 30'd0));
      chk(lk_fault == ef, req, "fault", 64'(lk_fault), 64'(ef));
      chk(lk_dirty_upd == ed, req, "dirty_upd", 64'(lk_dirty_upd), 64'(ed));
      @(posedge clk);
      #1 lk_valid = 1'b0; lk_write = 1'b0;
   endtask

   initial begin
      #1500000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R10: empty after reset
      look("R10", 8'd1, 20'h00010, 1'b0, 1'b0, 18'h0, 1'b0, 1'b0);
      lk_valid = 1'b0;

      fill(8'd1, 20'h00010, 18'h00AA1, 1'b1, 1'b1, 1'b0);
      fill(8'd2, 20'h00010, 18'h00BB2, 1'b1, 1'b0, 1'b0);
      fill(8'd1, 20'h00020, 18'h3FFFF, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 9; i++) begin
         look($sformatf("vector%0d", i), VEC[i].asid, VEC[i].vpn, VEC[i].wr,
              VEC[i].hit, VEC[i].ppn, VEC[i].fault, VEC[i].du);
      end

      // R5: refill of present tag overwrites it
      fill(8'd1, 20'h00010, 18'h12345, 1'b1, 1'b1, 1'b0);
      look("R5", 8'd1, 20'h00010, 1'b0, 1'b1, 18'h12345, 1'b0, 1'b0);

      // R8: per-process flush
      @(negedge clk);
      flush_asid_en = 1'b1; flush_asid = 8'd1;
      @(negedge clk);
      flush_asid_en = 1'b0;
      look("R8", 8'd1, 20'h00010, 1'b0, 1'b0, 18'h0, 1'b0, 1'b0);
      look("R8", 8'd1, 20'h00020, 1'b1, 1'b0, 18'h0, 1'b0, 1'b0);
      look("R8", 8'd2, 20'h00010, 1'b0, 1'b1, 18'h00BB2, 1'b0, 1'b0);

      // R9: global flush beats a simultaneous refill
      @(negedge clk);
      flush_all = 1'b1; fill_en = 1'b1; fill_asid = 8'd4; fill_vpn = 20'h00044;
      fill_ppn = 18'h00444; fill_rd = 1'b1; fill_wr = 1'b1;
      @(negedge clk);
      flush_all = 1'b0; fill_en = 1'b0;
      look("R9", 8'd2, 20'h00010, 1'b0, 1'b0, 18'h0, 1'b0, 1'b0);
      look("R9", 8'd4, 20'h00044, 1'b0, 1'b0, 18'h0, 1'b0, 1'b0);

      // R6 / R7: placement and clock replacement
      do_reset();
      for (int i = 0; i < 16; i++) begin
         fill((i == 5) ? 8'd9 : 8'd1, 20'(i), 18'(i + 32), 1'b1, 1'b1, 1'b0);
      end
      @(negedge clk);
      flush_asid_en = 1'b1; flush_asid = 8'd9;
      @(negedge clk);
      flush_asid_en = 1'b0;
      fill(8'd1, 20'd200, 18'h00200, 1'b1, 1'b1, 1'b0);
      look("R6", 8'd1, 20'd0, 1'b0, 1'b1, 18'd32, 1'b0, 1'b0);
      look("R6", 8'd1, 20'd200, 1'b0, 1'b1, 18'h00200, 1'b0, 1'b0);
      fill(8'd1, 20'd100, 18'h00100, 1'b1, 1'b1, 1'b0);  // all used: evicts line 0
      look("R7", 8'd1, 20'd2, 1'b0, 1'b1, 18'd34, 1'b0, 1'b0); // mark line 2 used
      fill(8'd1, 20'd101, 18'h00101, 1'b1, 1'b1, 1'b0);  // evicts line 1
      fill(8'd1, 20'd102, 18'h00102, 1'b1, 1'b1, 1'b0);  // skips 2, evicts line 3
      look("R7", 8'd1, 20'd0, 1'b0, 1'b0, 18'h0, 1'b0, 1'b0);
      look("R7", 8'd1, 20'd1, 1'b0, 1'b0, 18'h0, 1'b0, 1'b0);
      look("R7", 8'd1, 20'd2, 1'b0, 1'b1, 18'd34, 1'b0, 1'b0);
      look("R7", 8'd1, 20'd3, 1'b0, 1'b0, 18'h0, 1'b0, 1'b0);
      look("R7", 8'd1, 20'd4, 1'b0, 1'b1, 18'd36, 1'b0, 1'b0);
      look("R7", 8'd1, 20'd100, 1'b0, 1'b1, 18'h00100, 1'b0, 1'b0);
      look("R7", 8'd1, 20'd101, 1'b0, 1'b1, 18'h00101, 1'b0, 1'b0);
      look("R7", 8'd1, 20'd102, 1'b0, 1'b1, 18'h00102, 1'b0, 1'b0);
      look("R6", 8'd1, 20'd200, 1'b0, 1'b1, 18'h00200, 1'b0, 1'b0);

      // R1: idle lookup port reports no hit
      @(negedge clk);
      lk_valid = 1'b0; lk_asid = 8'd1; lk_vaddr = {20'd4, OFS};
      #2;
      chk(lk_hit == 1'b0, "R1", "idle hit", 64'(lk_hit), 64'd0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule